// File: doc/BRIEF.md
# Underrun Interrupt Flag with Output Word Hold

This block sits at the output end of a streaming engine. Words fetched from memory reach the output bus one cycle after they are offered. When the fetch side runs dry, the block keeps driving the last word it captured. The same word may therefore appear on the bus for several cycles in a row, and a downstream receiver that knows the message length may see this as extra samples.

An underrun status input reports when the streamer has run out of words. The block turns the start of each underrun episode into a sticky pending flag for software. The flag stays set until software acknowledges it by writing a one through a register write strobe. Because the flag follows the rising edge of the underrun status and not its level, an acknowledge during an underrun that is still going on leaves the flag clear. Only a later exit from the underrun state and a new entry into it raise the flag again. The interrupt line is the pending flag gated by an enable.

Top module: `uev_irq_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) forces out_data_o to 0, pend_o to 0 and irq_o to 0.
- R2: If smp_valid_i is high at a clock edge, out_data_o equals the smp_data_i value sampled at that edge, starting one cycle later.
- R3: If smp_valid_i is low at a clock edge, out_data_o keeps its previous value, whatever smp_data_i carries, so the last word is repeated.
- R4: A clock edge at which underrun_i is 1 and was 0 at the previous edge (or at which reset was active) sets pend_o to 1 from the following cycle.
- R5: Once set, pend_o stays 1 until it is acknowledged, including after underrun_i returns to 0.
- R6: A clock edge with ack_wr_i = 1 and ack_bit_i = 1 and no set event at that edge clears pend_o from the following cycle.
- R7: If pend_o is cleared while underrun_i stays 1, pend_o stays 0 for as long as underrun_i stays 1.
- R8: After underrun_i goes to 0 and then back to 1, pend_o is set again.
- R9: If a set event and an acknowledge write happen at the same clock edge, pend_o is 1 afterwards.
- R10: A write with ack_wr_i = 1 and ack_bit_i = 0, or ack_bit_i = 1 with ack_wr_i = 0, leaves pend_o unchanged.
- R11: irq_o equals pend_o AND irq_en_i at all times, and irq_en_i never changes pend_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| underrun_i | input | 1 | Underrun status of the streamer, 1 while no word is available |
| smp_valid_i | input | 1 | A new fetched word is present on smp_data_i |
| smp_data_i | input | DATA_W | Fetched word |
| out_data_o | output | DATA_W | Output data bus, holds the last captured word |
| ack_wr_i | input | 1 | Write strobe for the acknowledge register |
| ack_bit_i | input | 1 | Value written to the acknowledge bit, 1 clears the flag |
| irq_en_i | input | 1 | Interrupt enable |
| pend_o | output | 1 | Sticky pending flag, readable status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench acknowledges the flag in the middle of a long underrun and watches it stay low. A level-sensitive design would raise it again on the next cycle. It then leaves and re-enters the underrun state to show that a new edge sets the flag again. A design that stored an "acknowledged" bit without clearing it on exit would never report the second episode. The bench also places an acknowledge on the same edge as a rising underrun, where a design that gives the clear priority would lose the event. It writes zero to the acknowledge bit and toggles the enable to show that neither touches the stored flag. During hold periods it changes the fetch data while valid is low, which catches a register that loads without checking valid.

// File: rtl/uev_pkg.sv
// Package: shared types for the underrun interrupt block.
// Assumes: nothing beyond a single clock domain.
package uev_pkg;

    // Next-state action chosen for the sticky pending flag.
    typedef enum logic [1:0] {
        FLAG_KEEP  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_e;

endpackage

// File: rtl/uev_edge_det.sv
// Module: uev_edge_det
// Registers a level signal and reports a one-cycle rise when the level is
// high now and the registered copy is low.
// Assumes: level_i is synchronous to clk; the registered copy resets to 0,
// so a level already high out of reset counts as a rise.
module uev_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    // Keep the previous-cycle copy of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    // Rise is current high with previous low.
    always_comb rise_o = level_i & ~level_q;

    // A rise can never be reported two edges in a row.
    assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/uev_sticky_flag.sv
// Module: uev_sticky_flag
// Sticky flag that is set by set_i and cleared by clr_i. A set wins over a
// clear that arrives at the same edge.
// Assumes: set_i is a single-cycle event; clr_i is already qualified.
module uev_sticky_flag
    import uev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_act_e act;
    logic      flag_q;

    // Select the action, with set taking priority.
    always_comb begin
        if (set_i)      act = FLAG_SET;
        else if (clr_i) act = FLAG_CLEAR;
        else            act = FLAG_KEEP;
    end

    // Apply the action to the stored flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            unique case (act)
                FLAG_SET:   flag_q <= 1'b1;
                FLAG_CLEAR: flag_q <= 1'b0;
                default:    flag_q <= flag_q;
            endcase
        end
    end

    always_comb flag_o = flag_q;

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);

endmodule

// File: rtl/uev_hold_reg.sv
// Module: uev_hold_reg
// Output word register: loads a new word when valid, otherwise keeps
// driving the last word so it repeats on the bus during an underrun.
// Assumes: valid_i and data_i are synchronous to clk.
module uev_hold_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] word_q;

    // Capture a word when one is offered, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (valid_i) word_q <= data_i;
    end

    always_comb data_o = word_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (data_o == $past(data_i)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(data_o));

endmodule

// File: rtl/uev_irq_top.sv
// Module: uev_irq_top
// Turns entry into the underrun state into a sticky pending flag with a
// gated interrupt, and holds the last fetched word on the output bus.
// Assumes: all inputs are synchronous to clk; an acknowledge is a write
// strobe with a one in the acknowledge bit.
module uev_irq_top #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              underrun_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              ack_wr_i,
    input  logic              ack_bit_i,
    input  logic              irq_en_i,
    output logic              pend_o,
    output logic              irq_o
);

    logic rise_w;
    logic ack_w;
    logic flag_w;

    uev_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (smp_valid_i),
        .data_i  (smp_data_i),
        .data_o  (out_data_o)
    );

    uev_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (underrun_i),
        .rise_o  (rise_w)
    );

    // Only a strobe carrying a one counts as an acknowledge.
    always_comb ack_w = ack_wr_i & ack_bit_i;

    uev_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (rise_w),
        .clr_i  (ack_w),
        .flag_o (flag_w)
    );

    // Expose the stored flag and gate the interrupt with the enable.
    always_comb begin
        pend_o = flag_w;
        irq_o  = flag_w & irq_en_i;
    end

    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !rise_w) |=> !pend_o);

    assert_reentry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_i && !$past(underrun_i)) |=> pend_o);

    assert_ack_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !(ack_wr_i && ack_bit_i)) |=> pend_o);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!pend_o && !irq_o && out_data_o == '0));

endmodule

// File: tb/tb_uev_irq_top.sv
module tb_uev_irq_top;

    localparam int DATA_W = 16;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              pend;
        logic              irq;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              underrun_i = 1'b0;
    logic              smp_valid_i = 1'b0;
    logic [DATA_W-1:0] smp_data_i = '0;
    logic [DATA_W-1:0] out_data_o;
    logic              ack_wr_i = 1'b0;
    logic              ack_bit_i = 1'b0;
    logic              irq_en_i = 1'b0;
    logic              pend_o;
    logic              irq_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // Reference state derived from the requirements.
    logic [DATA_W-1:0] m_data = '0;
    logic              m_flag = 1'b0;
    logic              m_prev = 1'b0;

    always #5 clk = ~clk;

    uev_irq_top #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .underrun_i(underrun_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
        .out_data_o(out_data_o), .ack_wr_i(ack_wr_i), .ack_bit_i(ack_bit_i),
        .irq_en_i(irq_en_i), .pend_o(pend_o), .irq_o(irq_o)
    );

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic rst, input logic und, input logic fv,
                        input logic [DATA_W-1:0] fd, input logic wr,
                        input logic wb, input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst; underrun_i = und; smp_valid_i = fv; smp_data_i = fd;
        ack_wr_i = wr; ack_bit_i = wb; irq_en_i = en;
        if (!rst) begin
            m_data = '0; m_flag = 1'b0; m_prev = 1'b0;
        end else begin
            if (fv) m_data = fd;
            if (und && !m_prev) m_flag = 1'b1;
            else if (wr && wb)  m_flag = 1'b0;
            m_prev = und;
        end
        e.data = m_data; e.pend = m_flag; e.irq = m_flag & en; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare outputs after each edge against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (out_data_o !== e.data || pend_o !== e.pend || irq_o !== e.irq) begin
                    errors++;
                    $display("FAIL %s: data=%h pend=%b irq=%b expected data=%h pend=%b irq=%b",
                             e.tag, out_data_o, pend_o, irq_o, e.data, e.pend, e.irq);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(0, 0, 0, 16'h0000, 0, 0, 1, "R1 reset");
        step(0, 1, 1, 16'hFFFF, 1, 1, 1, "R1 reset ignores inputs");
        // R2: loads
        step(1, 0, 1, 16'hA5A5, 0, 0, 1, "R2 load first");
        step(1, 0, 1, 16'h1234, 0, 0, 1, "R2 load second");
        step(1, 0, 1, 16'h0001, 0, 0, 1, "R2 load third");
        // R3: hold with changing data
        step(1, 0, 0, 16'hDEAD, 0, 0, 1, "R3 hold");
        step(1, 0, 0, 16'hBEEF, 0, 0, 1, "R3 hold");
        // R4: underrun begins, word repeats
        step(1, 1, 0, 16'hCAFE, 0, 0, 1, "R4 rise sets flag");
        step(1, 1, 0, 16'h5555, 0, 0, 1, "R3 R4 hold in underrun");
        step(1, 1, 1, 16'h7777, 0, 0, 1, "R2 load after underrun");
        // R5: flag sticky after exit
        step(1, 0, 0, 16'h0000, 0, 0, 1, "R5 sticky after exit");
        step(1, 0, 0, 16'h0000, 0, 0, 1, "R5 sticky");
        // R10: writes that must not clear
        step(1, 0, 0, 16'h0000, 1, 0, 1, "R10 write zero");
        step(1, 0, 0, 16'h0000, 0, 1, 1, "R10 bit without strobe");
        // R6: acknowledge
        step(1, 0, 0, 16'h0000, 1, 1, 1, "R6 ack clears");
        step(1, 0, 0, 16'h0000, 0, 0, 1, "R6 stays clear");
        // R7: ack during ongoing underrun
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R8 new episode sets");
        step(1, 1, 0, 16'h0000, 1, 1, 1, "R7 ack mid underrun");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R7 no retrigger");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R7 no retrigger");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R7 no retrigger");
        // R8: exit and re-entry
        step(1, 0, 1, 16'h3C3C, 0, 0, 1, "R8 exit");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R8 re-entry sets");
        step(1, 0, 0, 16'h0000, 1, 1, 1, "R6 ack after exit");
        // R9: set and ack same edge
        step(1, 1, 0, 16'h0000, 1, 1, 1, "R9 set wins");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R9 still set");
        // R11: enable gating
        step(1, 1, 0, 16'h0000, 0, 0, 0, "R11 irq masked");
        step(1, 0, 0, 16'h0000, 0, 0, 0, "R11 flag kept");
        step(1, 0, 0, 16'h0000, 0, 0, 1, "R11 irq returns");
        step(1, 0, 0, 16'h0000, 1, 1, 0, "R11 ack while masked");
        step(1, 0, 0, 16'h0000, 0, 0, 1, "R11 enable no set");
        // R1: underrun high through reset counts as entry
        step(0, 1, 0, 16'h0000, 0, 0, 1, "R1 mid run reset");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R4 high out of reset");
        step(1, 1, 0, 16'h0000, 0, 0, 1, "R5 held");
        @(negedge clk);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule